// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a register with the outcomes of the most recent resolved branches and a table of two-bit saturating counters. At fetch the program counter comes in. A few of its bits, with the low alignment bits dropped, are combined by XOR with the history register to pick one counter. The upper bit of that counter is the prediction.

The index that made the prediction is returned on the same cycle as the prediction. The pipeline carries it to the execute stage. When the branch resolves there, the pipeline returns that index with a valid strobe and the real outcome. The same counter then moves one step toward the outcome, and the history takes the outcome in at its low end. Cycles without a real resolution leave all state untouched. Target prediction, flushing and decode belong to neighbouring blocks.

Top module: `gsp_predictor`

## Requirements
- R1: `pred_idx` equals `fetch_pc[PC_LSB+HIST_W-1:PC_LSB]` XOR the current history (defaults: `fetch_pc[9:2]`, 8-bit history, 256 counters). It is valid combinationally in the same cycle as `fetch_pc`.
- R2: After reset the history is zero and every counter holds 1 (weakly not taken), so every lookup predicts not taken.
- R3: `pred_taken` is bit 1 of the counter selected by `pred_idx`. The counter code is 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken.
- R4: A valid update with `upd_taken`=1 raises the counter at `upd_idx` by one, and a counter at 3 stays at 3.
- R5: A valid update with `upd_taken`=0 lowers the counter at `upd_idx` by one, and a counter at 0 stays at 0.
- R6: An update changes only the counter addressed by `upd_idx`. Every other counter keeps its value.
- R7: Each valid update shifts the history left by one, with `upd_taken` entering at bit 0.
- R8: While `upd_valid` is 0, neither the table nor the history changes, whatever `upd_idx` and `upd_taken` carry.
- R9: A lookup in the same cycle as an update sees the table and history from before that update. The update becomes visible on the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address of the instruction being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | HIST_W | Table index used for this prediction |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_idx | input | HIST_W | Index carried from fetch for the resolving branch |
| upd_taken | input | 1 | Real outcome of the resolving branch, 1 = taken |

## Verification
The prediction and its index are combinational, so the bench drives `fetch_pc` on the falling edge and samples one time unit later in that same half cycle. An update is registered at the next rising edge, and its effect on both the counter and the history is due on the lookup that follows that edge. The bench updates its model at that edge and checks on the following falling edge. For R9 a lookup is held in the cycle of the update and is expected to show the old values. The idle-strobe case is checked by sweeping all table entries after many cycles of garbage on the update inputs.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_INIT = 2'd1;
   localparam ctr_t CTR_MAX  = 2'd3;
   localparam ctr_t CTR_MIN  = 2'd0;

   // one saturating step toward the observed outcome
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
      else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/gsp_history.sv
module gsp_history #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_in,
   output logic [HIST_W-1:0] hist_o
);

   logic [HIST_W-1:0] hist_q;

   generate
      if (HIST_W == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= shift_in;
         end
      end else begin : g_wide
         always_ff @(posedge clk) begin
            if (!rst_n)        hist_q <= '0;
            else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_in};
         end
      end
   endgenerate

   assign hist_o = hist_q;

   // R7
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist_q[0] == $past(shift_in));

   // R8
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gsp_hash.sv
module gsp_hash #(
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter int HIST_W = 8
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [HIST_W-1:0] idx
);

   logic [PC_W-1:0] unused_pc_all;
   assign unused_pc_all = pc;

   generate
      for (genvar b = 0; b < HIST_W; b++) begin : g_bit
         assign idx[b] = pc[PC_LSB+b] ^ hist[b];
      end
   endgenerate

endmodule

// File: rtl/gsp_pht.sv
module gsp_pht
   import gsp_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int DEPTH = 1 << IDX_W;

   ctr_t ctr_all [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         ctr_t c_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               c_q <= CTR_INIT;
            else if (wr_en && (wr_idx == IDX_W'(e)))
               c_q <= ctr_step(c_q, wr_taken);
         end
         assign ctr_all[e] = c_q;
      end
   endgenerate

   assign rd_taken = ctr_all[rd_idx][1];

   // R4
   sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && ctr_all[wr_idx] == CTR_MAX) |=> ctr_all[$past(wr_idx)] == CTR_MAX);

   // R5
   sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && ctr_all[wr_idx] == CTR_MIN) |=> ctr_all[$past(wr_idx)] == CTR_MIN);

   // R8
   tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ctr_all[$past(rd_idx)] == $past(ctr_all[rd_idx]));

endmodule

// File: rtl/gsp_predictor.sv
module gsp_predictor #(
   parameter int PC_W   = 32,
   parameter int PC_LSB = 2,
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   fetch_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_idx,
   input  logic              upd_valid,
   input  logic [HIST_W-1:0] upd_idx,
   input  logic              upd_taken
);

   generate
      if (HIST_W < 1 || HIST_W > 12) begin : g_bad_hist
         $error("HIST_W must lie in 1..12");
      end
      if (PC_LSB + HIST_W > PC_W) begin : g_bad_slice
         $error("PC slice exceeds PC_W");
      end
   endgenerate

   logic [HIST_W-1:0] hist;

   gsp_history #(.HIST_W(HIST_W)) i_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (upd_valid),
      .shift_in (upd_taken),
      .hist_o   (hist)
   );

   gsp_hash #(.PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_W(HIST_W)) i_hash (
      .pc   (fetch_pc),
      .hist (hist),
      .idx  (pred_idx)
   );

   gsp_pht #(.IDX_W(HIST_W)) i_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (pred_idx),
      .rd_taken (pred_taken),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   // R1
   idx_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_idx ^ hist) == fetch_pc[PC_LSB+HIST_W-1:PC_LSB]);

endmodule

// File: tb/test_gsp_predictor.sv
module test_gsp_predictor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken;
   logic [7:0]  pred_idx;
   logic        upd_valid = 1'b0;
   logic [7:0]  upd_idx = '0;
   logic        upd_taken = 1'b0;

   int checks = 0;
   int errors = 0;

   logic [1:0] mtab [256];
   logic [7:0] mhist;

   always #5 clk = ~clk;

   gsp_predictor i_gsp_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_taken(pred_taken), .pred_idx(pred_idx),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pc_for(input logic [7:0] idx);
      logic [31:0] r = $urandom;
      r[9:2] = idx ^ mhist;
      return r;
   endfunction

   function automatic logic [1:0] step(input logic [1:0] c, input logic t);
      if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
      return (c == 2'd0) ? 2'd0 : c - 2'd1;
   endfunction

   task automatic model_upd(input logic [7:0] idx, input logic t);
      mtab[idx] = step(mtab[idx], t);
      mhist = {mhist[6:0], t};
   endtask

   // lookup checked against the model: index (R1) and counter MSB (R3)
   task automatic lookup(input logic [31:0] pc, input string req);
      logic [7:0] e;
      @(negedge clk);
      fetch_pc = pc;
      #1;
      e = pc[9:2] ^ mhist;
      chk(pred_idx, e, {"R1 ", req});
      chk(pred_taken, mtab[e][1], {"R3 ", req});
   endtask

   task automatic lookup_exp(input logic [7:0] idx, input logic exp, input string req);
      @(negedge clk);
      fetch_pc = pc_for(idx);
      #1;
      chk(pred_idx, idx, req);
      chk(pred_taken, exp, req);
   endtask

   task automatic update(input logic [7:0] idx, input logic t);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_idx = idx;
      upd_taken = t;
      @(posedge clk);
      model_upd(idx, t);
      #1;
      upd_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mtab[i] = 2'd1;
      mhist = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: every index predicts not taken, history zero so idx == PC slice
      for (int i = 0; i < 256; i++) begin
         logic [31:0] p = $urandom;
         p[9:2] = 8'(i);
         @(negedge clk);
         fetch_pc = p;
         #1;
         chk(pred_idx, i, "R2 idx");
         chk(pred_taken, 0, "R2 pred");
      end

      // R9: lookup in the update cycle sees old state
      @(negedge clk);
      fetch_pc = pc_for(8'h5A);
      upd_valid = 1'b1;
      upd_idx = 8'h5A;
      upd_taken = 1'b1;
      #1;
      chk(pred_idx, 8'h5A, "R9 old idx");
      chk(pred_taken, 0, "R9 old pred");
      @(posedge clk);
      model_upd(8'h5A, 1'b1);
      #1;
      upd_valid = 1'b0;
      lookup_exp(8'h5A, 1'b1, "R9 new pred");
      chk(mhist, 8'h01, "R7 hist after one taken");

      // R4: saturate high (counter now 2)
      for (int k = 0; k < 3; k++) begin
         update(8'h5A, 1'b1);
         lookup_exp(8'h5A, 1'b1, "R4");
      end
      // R5: walk down 3->2->1->0->0->0
      update(8'h5A, 1'b0); lookup_exp(8'h5A, 1'b1, "R5 2");
      update(8'h5A, 1'b0); lookup_exp(8'h5A, 1'b0, "R5 1");
      update(8'h5A, 1'b0); lookup_exp(8'h5A, 1'b0, "R5 0");
      update(8'h5A, 1'b0); lookup_exp(8'h5A, 1'b0, "R5 sat");
      update(8'h5A, 1'b0); lookup_exp(8'h5A, 1'b0, "R5 sat");
      // leaving 0 proves saturation held at 0: 0->1 still NT, 1->2 taken
      update(8'h5A, 1'b1); lookup_exp(8'h5A, 1'b0, "R5 from0");
      update(8'h5A, 1'b1); lookup_exp(8'h5A, 1'b1, "R4 from1");

      // R7/R3/R6: random training against the model
      for (int n = 0; n < 600; n++) begin
         logic [7:0] ix = 8'($urandom_range(0, 31));
         update(ix, 1'($urandom));
         lookup($urandom, "R7 rand");
      end

      // R8: garbage on update inputs with strobe low
      @(negedge clk);
      upd_valid = 1'b0;
      for (int n = 0; n < 20; n++) begin
         upd_idx = 8'($urandom);
         upd_taken = 1'($urandom);
         @(negedge clk);
      end
      for (int i = 0; i < 256; i++) lookup(pc_for(8'(i)), "R8 R6 sweep");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule